// File: doc/BRIEF.md
# Double-Width Funnel Left Shifter

This unit shifts a destination word to the left by a variable count. The low bit positions that the shift empties are not filled with zeros. They take the most significant bits of a second word, the fill operand. Software uses this to shift values wider than one machine word: each word of a multiword value is combined with its lower neighbour. The unit also produces the carry, sign, zero and parity status flags for the new value.

The operand width is 16 or 32 bits and is chosen per operation. The 8-bit count is always reduced to its low five bits, whatever the width. A reduced count of zero is a no-op. In 16-bit mode a reduced count of 16 or more is an undefined case. For every undefined case the unit drives a fixed, documented outcome and raises a status output.

Each operation is launched with a one-cycle start strobe. All outputs are registered and appear together one cycle later, marked by a single-cycle done pulse. The fill word is sampled in the same cycle as the destination, so a caller may pass the same storage as both operands.

Top module: `dwl_funnel_shift`

## Requirements
- R1: The shift amount is `count_i[4:0]`; bits 7:5 of the count are ignored in both widths, so counts 1 and 33 give identical outputs.
- R2: When the shift amount is 0, `res_o` equals the destination (low 16 bits, zero-extended, in 16-bit mode), all six flags keep their values and `flag_we_o` stays low with `done_o`.
- R3: For a valid amount s (0 < s < N, with N = 32 when `wide_i`=1 and N = 16 when `wide_i`=0), result bit i for N-1 >= i >= s equals destination bit i-s.
- R4: For a valid amount s, result bit i for s-1 >= i >= 0 equals fill bit i-s+N, so the top s fill bits enter from the right.
- R5: For a valid amount s, `cf_o` becomes destination bit N-s, which is the last bit pushed out of the top.
- R6: For a valid amount, `sf_o` is result bit N-1, `zf_o` is 1 exactly when result bits N-1..0 are all zero, and `pf_o` is 1 exactly when result bits 7..0 hold an even number of ones.
- R7: `of_o` and `af_o` are never changed by any operation; they keep their reset value of 0.
- R8: With `wide_i`=0 and a shift amount of 16..31, `res_o` equals the zero-extended low half of the destination, all flags keep their values, and `undef_o` and `flag_we_o` are high together with `done_o`.
- R9: With `wide_i`=0, bits 31:16 of `dst_i` and `fill_i` have no effect and `res_o[31:16]` is 0.
- R10: `done_o` is high for exactly the one cycle after each cycle in which `start_i` is high; `flag_we_o` and `undef_o` are only ever high with `done_o`; all outputs hold between operations.
- R11: After a synchronous reset (`rst_n` low at a clock edge), `res_o`, all flags, `done_o`, `flag_we_o` and `undef_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launches an operation this cycle |
| wide_i | input | 1 | 1 selects 32-bit operands, 0 selects 16-bit |
| count_i | input | 8 | Shift count; only bits 4:0 are used |
| dst_i | input | 32 | Destination word to be shifted |
| fill_i | input | 32 | Word whose top bits fill the vacated positions |
| res_o | output | 32 | Shifted result |
| cf_o | output | 1 | Carry flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (even parity of the low byte) |
| of_o | output | 1 | Overflow flag (held) |
| af_o | output | 1 | Auxiliary carry flag (held) |
| flag_we_o | output | 1 | Flag write enable, valid with done |
| undef_o | output | 1 | Operation fell into the undefined case |
| done_o | output | 1 | Result and flags are valid this cycle |

## Verification
The result, the flags, the flag write enable and the undefined marker all move in the cycle after the start strobe, through a single register stage. Each task raises `start_i` on a falling edge and drops it one cycle later. It samples every output on the next falling edge, where `done_o` must be high. On the falling edge after that it samples again and expects `done_o` low with the result unchanged. The flags expected for no-op and undefined operations are the values the bench's model recorded for the last valid operation.

// File: rtl/dwl_pkg.sv
// Package dwl_pkg
// Shared types for the funnel left shifter: the classification of an
// operation and the packed status flag bundle.
package dwl_pkg;

    // Operation class decided from count and width
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_SHIFT = 2'd1,
        OP_UNDEF = 2'd2
    } op_class_e;

    // Status flag bundle held by the unit
    typedef struct packed {
        logic cf;
        logic sf;
        logic zf;
        logic pf;
        logic of;
        logic af;
    } flags_t;

endpackage

// File: rtl/dwl_count_decode.sv
// Module dwl_count_decode
// Reduces the raw count to its low AMT_W bits and classifies the operation
// as a no-op (amount zero), an undefined narrow shift (amount at or above
// the narrow width) or a normal shift. Purely combinational.
// Assumes NARROW_W fits in AMT_W bits.
module dwl_count_decode
    import dwl_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int AMT_W    = 5,
    parameter int NARROW_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             wide_i,
    output logic [AMT_W-1:0] amt_o,
    output op_class_e        cls_o
);

    localparam logic [AMT_W-1:0] NARROW_LIM = AMT_W'(NARROW_W);

    logic unused_count_hi;

    // Upper count bits are discarded by design
    assign unused_count_hi = ^count_i[CNT_W-1:AMT_W];
    assign amt_o           = count_i[AMT_W-1:0];

    // Classify the operation from amount and width
    always_comb begin
        if (amt_o == '0) begin
            cls_o = OP_NOP;
        end else if (!wide_i && (amt_o >= NARROW_LIM)) begin
            cls_o = OP_UNDEF;
        end else begin
            cls_o = OP_SHIFT;
        end
    end

endmodule

// File: rtl/dwl_funnel_core.sv
// Module dwl_funnel_core
// Funnel shifter of width W: concatenates destination above fill, shifts
// the pair left by amt_i, and returns the upper W bits plus the last bit
// pushed out of the top. Combinational.
// Assumes amt_i < W whenever the outputs are used.
module dwl_funnel_core #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     dst_i,
    input  logic [W-1:0]     fill_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     res_o,
    output logic             cout_o
);

    localparam int EXT_W = 2 * W + 1;

    logic [EXT_W-1:0] ext_in;
    logic [EXT_W-1:0] ext_sh;

    // Guard bit above the pair catches the final carry out
    assign ext_in = {1'b0, dst_i, fill_i};
    assign ext_sh = ext_in << amt_i;
    assign res_o  = ext_sh[2*W-1:W];
    assign cout_o = ext_sh[2*W];

endmodule

// File: rtl/dwl_flag_gen.sv
// Module dwl_flag_gen
// Derives sign, zero and parity flags from a result word whose active
// width is W when wide_i is high and NARROW_W otherwise. Parity covers the
// low PAR_W bits only. Combinational.
// Assumes result bits above the active width are zero in narrow mode.
module dwl_flag_gen #(
    parameter int W        = 32,
    parameter int NARROW_W = 16,
    parameter int PAR_W    = 8
) (
    input  logic [W-1:0] res_i,
    input  logic         wide_i,
    output logic         sf_o,
    output logic         zf_o,
    output logic         pf_o
);

    // Sign and zero follow the active operand width
    always_comb begin
        if (wide_i) begin
            sf_o = res_i[W-1];
            zf_o = (res_i == '0);
        end else begin
            sf_o = res_i[NARROW_W-1];
            zf_o = (res_i[NARROW_W-1:0] == '0);
        end
    end

    // Even parity of the low byte
    assign pf_o = ~^res_i[PAR_W-1:0];

endmodule

// File: rtl/dwl_funnel_shift.sv
// Module dwl_funnel_shift (top)
// Double-width funnel left shifter with status flags. One operation is
// accepted per start_i pulse; result, flags, write enable and the
// undefined marker register one cycle later, flagged by done_o.
// Assumes start_i is a single-cycle strobe; inputs are sampled only then.
// Undefined narrow shifts return the destination and keep all flags.
module dwl_funnel_shift
    import dwl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int CNT_W    = 8,
    parameter int AMT_W    = 5,
    parameter int PAR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] fill_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o,
    output logic              of_o,
    output logic              af_o,
    output logic              flag_we_o,
    output logic              undef_o,
    output logic              done_o
);

    localparam int PAD_W = DATA_W - NARROW_W;

    logic [AMT_W-1:0]    amt;
    op_class_e           cls;
    logic [DATA_W-1:0]   wide_res;
    logic                wide_cout;
    logic [NARROW_W-1:0] nar_res;
    logic                nar_cout;
    logic [DATA_W-1:0]   sel_res;
    logic                sel_cout;
    logic [DATA_W-1:0]   dst_view;
    logic                new_sf;
    logic                new_zf;
    logic                new_pf;

    flags_t              flags_q;
    flags_t              flags_d;
    logic [DATA_W-1:0]   res_q;
    logic [DATA_W-1:0]   res_d;
    logic                done_q;
    logic                we_q;
    logic                we_d;
    logic                undef_q;
    logic                undef_d;

    dwl_count_decode #(
        .CNT_W   (CNT_W),
        .AMT_W   (AMT_W),
        .NARROW_W(NARROW_W)
    ) u_dec (
        .count_i(count_i),
        .wide_i (wide_i),
        .amt_o  (amt),
        .cls_o  (cls)
    );

    dwl_funnel_core #(
        .W    (DATA_W),
        .AMT_W(AMT_W)
    ) u_wide (
        .dst_i (dst_i),
        .fill_i(fill_i),
        .amt_i (amt),
        .res_o (wide_res),
        .cout_o(wide_cout)
    );

    dwl_funnel_core #(
        .W    (NARROW_W),
        .AMT_W(AMT_W)
    ) u_narrow (
        .dst_i (dst_i[NARROW_W-1:0]),
        .fill_i(fill_i[NARROW_W-1:0]),
        .amt_i (amt),
        .res_o (nar_res),
        .cout_o(nar_cout)
    );

    // Pick the width-matched shift result and destination view
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (wide_i) begin
                    sel_res  = wide_res;
                    sel_cout = wide_cout;
                    dst_view = dst_i;
                end else begin
                    sel_res  = {{PAD_W{1'b0}}, nar_res};
                    sel_cout = nar_cout;
                    dst_view = {{PAD_W{1'b0}}, dst_i[NARROW_W-1:0]};
                end
            end
        end else begin : g_same
            always_comb begin
                sel_res  = wide_i ? wide_res  : nar_res;
                sel_cout = wide_i ? wide_cout : nar_cout;
                dst_view = dst_i;
            end
        end
    endgenerate

    dwl_flag_gen #(
        .W       (DATA_W),
        .NARROW_W(NARROW_W),
        .PAR_W   (PAR_W)
    ) u_flags (
        .res_i (sel_res),
        .wide_i(wide_i),
        .sf_o  (new_sf),
        .zf_o  (new_zf),
        .pf_o  (new_pf)
    );

    // Next-state selection by operation class
    always_comb begin
        flags_d = flags_q;
        res_d   = res_q;
        we_d    = 1'b0;
        undef_d = 1'b0;
        if (start_i) begin
            unique case (cls)
                OP_SHIFT: begin
                    res_d      = sel_res;
                    flags_d.cf = sel_cout;
                    flags_d.sf = new_sf;
                    flags_d.zf = new_zf;
                    flags_d.pf = new_pf;
                    we_d       = 1'b1;
                end
                OP_UNDEF: begin
                    res_d   = dst_view;
                    we_d    = 1'b1;
                    undef_d = 1'b1;
                end
                default: begin
                    res_d = dst_view;
                end
            endcase
        end
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            we_q    <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            flags_q <= flags_d;
            res_q   <= res_d;
            done_q  <= start_i;
            we_q    <= we_d;
            undef_q <= undef_d;
        end
    end

    assign res_o     = res_q;
    assign cf_o      = flags_q.cf;
    assign sf_o      = flags_q.sf;
    assign zf_o      = flags_q.zf;
    assign pf_o      = flags_q.pf;
    assign of_o      = flags_q.of;
    assign af_o      = flags_q.af;
    assign flag_we_o = we_q;
    assign undef_o   = undef_q;
    assign done_o    = done_q;

endmodule

// File: rtl/dwl_funnel_shift_chk.sv
// Module dwl_funnel_shift_chk
// Protocol and rule checks on the ports of dwl_funnel_shift, bound to
// every instance of the top. Observes only; drives nothing.
module dwl_funnel_shift_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        wide_i,
    input logic [7:0]  count_i,
    input logic [31:0] dst_i,
    input logic [31:0] fill_i,
    input logic [31:0] res_o,
    input logic        cf_o,
    input logic        sf_o,
    input logic        zf_o,
    input logic        pf_o,
    input logic        of_o,
    input logic        af_o,
    input logic        flag_we_o,
    input logic        undef_o,
    input logic        done_o
);

    logic [5:0] flag_vec;
    assign flag_vec = {cf_o, sf_o, zf_o, pf_o, of_o, af_o};

    // R10: a start is answered by done in the next cycle
    a_r10_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R10: no done without a start in the previous cycle
    a_r10_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R10: write enable and undefined marker only with done
    a_r10_side_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_o || undef_o) |-> done_o);

    // R10: result holds while idle
    a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(res_o));

    // R2: zero amount leaves flags and suppresses the write enable
    a_r2_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && count_i[4:0] == 5'd0) |=> (!flag_we_o && $stable(flag_vec)));

    // R7: overflow and auxiliary carry never move
    a_r7_of_af_held: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ($stable(of_o) && $stable(af_o)));

    // R8: narrow amount of 16 or more is marked undefined and keeps flags
    a_r8_narrow_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wide_i && count_i[4]) |=> (undef_o && flag_we_o && $stable(flag_vec)));

    // R9: narrow results have a clear upper half
    a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wide_i) |=> (res_o[31:16] == 16'h0000));

endmodule

bind dwl_funnel_shift dwl_funnel_shift_chk u_chk (.*);

// File: tb/sim_dwl_funnel_shift.sv
// Directed bench for dwl_funnel_shift. Each scenario task drives one or
// more operations and checks every output against a bench-side model.
module sim_dwl_funnel_shift;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b1;
    logic [7:0]  count_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] fill_i = '0;
    logic [31:0] res_o;
    logic        cf_o, sf_o, zf_o, pf_o, of_o, af_o;
    logic        flag_we_o, undef_o, done_o;

    int checks = 0;
    int errors = 0;

    // model flag state: cf sf zf pf of af
    logic [5:0] mflags = '0;

    always #5 clk = ~clk;

    dwl_funnel_shift u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .count_i(count_i), .dst_i(dst_i), .fill_i(fill_i), .res_o(res_o),
        .cf_o(cf_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o), .of_o(of_o),
        .af_o(af_o), .flag_we_o(flag_we_o), .undef_o(undef_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive on falling edge, sample the next falling edge
    task automatic run_op(input string req, input logic wide, input logic [7:0] cnt,
                          input logic [31:0] d, input logic [31:0] f);
        int n;
        int s;
        logic [31:0] exp_res;
        logic [31:0] dv;
        logic exp_we, exp_undef;
        int ones;
        n = wide ? 32 : 16;
        s = int'(cnt % 8'd32);
        dv = wide ? d : {16'h0, d[15:0]};
        exp_we = 1'b0;
        exp_undef = 1'b0;
        exp_res = dv;
        if (s != 0 && s >= n) begin
            exp_we = 1'b1;
            exp_undef = 1'b1;
        end else if (s != 0) begin
            exp_we = 1'b1;
            exp_res = '0;
            for (int i = s; i < n; i++) exp_res[i] = d[i-s];
            for (int i = 0; i < s; i++) exp_res[i] = f[i-s+n];
            mflags[5] = d[n-s];
            mflags[4] = exp_res[n-1];
            mflags[3] = (exp_res == 32'h0);
            ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(exp_res[i]);
            mflags[2] = (ones % 2 == 0);
        end
        @(negedge clk);
        wide_i = wide; count_i = cnt; dst_i = d; fill_i = f; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dst_i = ~d; fill_i = ~f; count_i = ~cnt;
        chk({req, " done R10"}, 32'(done_o), 32'd1);
        chk({req, " result"}, res_o, exp_res);
        chk({req, " flags"}, 32'({cf_o, sf_o, zf_o, pf_o, of_o, af_o}), 32'(mflags));
        chk({req, " flag_we"}, 32'(flag_we_o), 32'(exp_we));
        chk({req, " undef"}, 32'(undef_o), 32'(exp_undef));
        @(negedge clk);
        chk({req, " done pulse R10"}, 32'({done_o, flag_we_o, undef_o}), 32'd0);
        chk({req, " hold R10"}, res_o, exp_res);
    endtask

    task automatic t_reset;
        chk("R11 reset result", res_o, 32'h0);
        chk("R11 reset flags", 32'({cf_o, sf_o, zf_o, pf_o, of_o, af_o}), 32'h0);
        chk("R11 reset strobes", 32'({done_o, flag_we_o, undef_o}), 32'h0);
    endtask

    task automatic t_wide_basic;
        run_op("R3 R4 R5 wide s4", 1'b1, 8'd4, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R3 R4 R5 wide s1", 1'b1, 8'd1, 32'h8000_0001, 32'hFFFF_FFFF);
        run_op("R3 R4 R5 wide s31", 1'b1, 8'd31, 32'h0000_0003, 32'h5555_5555);
        run_op("R3 R4 wide s16", 1'b1, 8'd16, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    endtask

    task automatic t_flags;
        run_op("R6 zero result", 1'b1, 8'd8, 32'h0000_0000, 32'h00FF_FFFF);
        run_op("R6 odd parity", 1'b1, 8'd8, 32'h0000_0000, 32'h01FF_FFFF);
        run_op("R6 sign", 1'b1, 8'd2, 32'h2000_0000, 32'h0);
        run_op("R7 of af after shifts", 1'b1, 8'd5, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    endtask

    task automatic t_modulo;
        run_op("R1 count 33", 1'b1, 8'd33, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R1 count 255", 1'b1, 8'd255, 32'h0000_0001, 32'h8000_0000);
        run_op("R1 narrow count 35", 1'b0, 8'd35, 32'h0000_1234, 32'h0000_ABCD);
    endtask

    task automatic t_zero;
        run_op("R2 count 0 wide", 1'b1, 8'd0, 32'hA5A5_5A5A, 32'hFFFF_0000);
        run_op("R2 count 64 narrow", 1'b0, 8'd64, 32'hFFFF_8001, 32'h1111_2222);
    endtask

    task automatic t_narrow;
        run_op("R9 narrow s4", 1'b0, 8'd4, 32'hFFFF_1234, 32'hEEEE_ABCD);
        run_op("R9 narrow s15", 1'b0, 8'd15, 32'h7777_0001, 32'h3333_FFFE);
        run_op("R9 narrow s1", 1'b0, 8'd1, 32'hFFFF_0000, 32'hFFFF_0000);
    endtask

    task automatic t_undef;
        run_op("R8 narrow s16", 1'b0, 8'd16, 32'h9999_4321, 32'hFFFF_FFFF);
        run_op("R8 narrow s31", 1'b0, 8'd31, 32'h1234_8765, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_basic();
        t_flags();
        t_modulo();
        t_zero();
        t_narrow();
        t_undef();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule